// File: doc/BRIEF.md
# Serially Loaded Bank Switching Mapper

This block sits on the write side of an 8-bit CPU bus and holds the bank selects that steer program and character memory. The CPU has only one data bit per write to work with. Five writes into the upper half of the address space build a 5-bit value in a marker-bit shift register. The fifth write commits that value to one of four internal registers. Address bits 14:13 of that fifth write pick the register. A write with data bit 7 set abandons a partial value and forces the program banking mode to its fixed-upper-bank setting.

The committed registers are the control word, two character bank selects and a program bank select. The control word decides how the other writes are read. Its bit 4 picks between 4 KiB and 8 KiB character banking. Its bits 3:2 pick among 32 KiB program banking, a fixed lower 16 KiB bank and a fixed upper 16 KiB bank. Its bits 1:0 give the nametable mirroring for the picture side. The physical address arithmetic and the memories are outside this block. It only presents the current selects.

The write port is a valid/ready stream with no back-pressure. `wr_ready` is held high. Every cycle with `wr_valid` high is one accepted CPU write. A write counts toward a load only when `wr_addr[15]` is 1.

Top module: `serial_bank_mapper`

## Requirements
- R1: An accepted write with `wr_addr[15]` = 0, or any cycle with `wr_valid` low, changes neither the partial load nor any output.
- R2: Each accepted window write with `wr_data[7]` = 0 contributes `wr_data[0]`. The first write supplies bit 0 of the value and the fifth supplies bit 4. After fewer than five such writes no output changes. After the fifth write the target register shows the value on the next cycle, and the load starts empty again.
- R3: An accepted window write with `wr_data[7]` = 1 empties the partial load and sets control bits 3:2 to 11. Control bits 4, 1 and 0 are kept, and no other register changes.
- R4: The fifth write's `wr_addr[14:13]` selects the target register: 0 control, 1 character low, 2 character high, 3 program.
- R5: `mirror_mode` equals control bits 1:0, encoded 00 single-screen lower, 01 single-screen upper, 10 vertical, 11 horizontal. `ctrl_value` shows all five control bits.
- R6: A character-low commit with control bit 4 set loads `chr_lo4k_bank` with all five bits. With bit 4 clear it loads `chr_8k_bank` with the value ANDed with 0x1E. Either way the other of those two selects is left unchanged.
- R7: A character-high commit loads `chr_hi4k_bank` with all five bits only when control bit 4 is set. Otherwise it changes nothing.
- R8: `prg_mode` equals control bits 3:2. A program commit in mode 00 or 01 loads `prg_bank32` with value bits 3:1 and leaves the 16 KiB selects unchanged.
- R9: A program commit in mode 10 sets `prg_bank_lo` to 0 and `prg_bank_hi` to value bits 3:0.
- R10: A program commit in mode 11 sets `prg_bank_lo` to value bits 3:0 and `prg_bank_hi` to the last bank, PRG_BANKS-1.
- R11: After reset the control register is 0x0C and the load is empty. `prg_bank_hi` is PRG_BANKS-1 and every other select is 0.
- R12: `wr_ready` is 1 in every cycle, so no write is ever stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | CPU write strobe |
| wr_ready | output | 1 | Always 1; the port never stalls |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data; bit 0 is the serial bit, bit 7 the clear |
| ctrl_value | output | 5 | Control register |
| mirror_mode | output | 2 | Mirroring mode |
| chr_lo4k_bank | output | 5 | 4 KiB character bank at picture address 0x0000 |
| chr_hi4k_bank | output | 5 | 4 KiB character bank at picture address 0x1000 |
| chr_8k_bank | output | 5 | 8 KiB character bank select (bit 0 always 0) |
| prg_mode | output | 2 | Program banking mode |
| prg_bank_lo | output | PRG_W | 16 KiB program bank at CPU 0x8000 |
| prg_bank_hi | output | PRG_W | 16 KiB program bank at CPU 0xC000 |
| prg_bank32 | output | PRG_W-1 | 32 KiB program bank select |

## Verification
Some rules are checked by assertions in every cycle:
- the partial load holds still when no window write arrives;
- the load returns to empty after a commit or a clear;
- a clear write forces control bits 3:2 high without touching the bank selects;
- a character-high write in 8 KiB mode leaves that select alone;
- the fixed program bank lands as the mode requires.

Only the bench scenarios show the rest. That covers the bit order of a five-write value and the address decode. It also covers the masking in 8 KiB mode, the mirroring encodings and the 32 KiB bank derivation. Finally, it shows that an out-of-window or clearing write does not shift a later load out of alignment.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam int LOAD_W = 5;
  localparam logic [LOAD_W-1:0] LOAD_EMPTY = 5'b10000;
  localparam logic [LOAD_W-1:0] CTRL_RESET = 5'b01100;

  typedef enum logic [1:0] {
    TGT_CTRL   = 2'd0,
    TGT_CHR_LO = 2'd1,
    TGT_CHR_HI = 2'd2,
    TGT_PRG    = 2'd3
  } target_e;

  typedef enum logic [1:0] {
    MIR_ONE_LO = 2'd0,
    MIR_ONE_HI = 2'd1,
    MIR_VERT   = 2'd2,
    MIR_HORZ   = 2'd3
  } mirror_e;

  typedef enum logic [1:0] {
    PM_32K_A   = 2'd0,
    PM_32K_B   = 2'd1,
    PM_FIX_LO  = 2'd2,
    PM_FIX_HI  = 2'd3
  } prg_mode_e;
endpackage

// File: rtl/sbm_serial_loader.sv
module sbm_serial_loader
  import sbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              bit_in,
  input  logic              flush,
  output logic              commit,
  output logic [LOAD_W-1:0] commit_val
);
  logic [LOAD_W-1:0] shreg;

  // The marker reaching bit 0 means four bits are already held.
  assign commit     = take && !flush && shreg[0];
  assign commit_val = {bit_in, shreg[LOAD_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= LOAD_EMPTY;
    end else if (take) begin
      if (flush || shreg[0]) shreg <= LOAD_EMPTY;
      else                   shreg <= {bit_in, shreg[LOAD_W-1:1]};
    end
  end

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(shreg));
  // R3
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && flush) |=> (shreg == LOAD_EMPTY));
  // R2
  commit_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (shreg == LOAD_EMPTY));
  // R2
  marker_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(shreg) >= 1);
endmodule

// File: rtl/sbm_bank_regs.sv
module sbm_bank_regs
  import sbm_pkg::*;
#(
  parameter int PRG_BANKS = 16,
  localparam int PRG_W = $clog2(PRG_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [LOAD_W-1:0] commit_val,
  input  logic [1:0]        target,
  input  logic              flush,
  output logic [LOAD_W-1:0] ctrl_q,
  output logic [LOAD_W-1:0] chr_lo4k,
  output logic [LOAD_W-1:0] chr_hi4k,
  output logic [LOAD_W-1:0] chr_8k,
  output logic [PRG_W-1:0]  prg_lo,
  output logic [PRG_W-1:0]  prg_hi,
  output logic [PRG_W-2:0]  prg_32k
);
  localparam logic [PRG_W-1:0] LAST_BANK = PRG_W'(PRG_BANKS - 1);

  target_e         tgt;
  prg_mode_e       pmode;
  logic            chr4k_mode;
  logic [PRG_W-1:0] pval;

  assign tgt        = target_e'(target);
  assign pmode      = prg_mode_e'(ctrl_q[3:2]);
  assign chr4k_mode = ctrl_q[4];
  assign pval       = commit_val[PRG_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
    end else if (commit && tgt == TGT_CTRL) begin
      ctrl_q <= commit_val;
    end else if (flush) begin
      ctrl_q[3:2] <= 2'b11;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chr_lo4k <= '0;
      chr_hi4k <= '0;
      chr_8k   <= '0;
    end else if (commit) begin
      if (tgt == TGT_CHR_LO) begin
        if (chr4k_mode) chr_lo4k <= commit_val;
        else            chr_8k   <= commit_val & 5'h1E;
      end
      if (tgt == TGT_CHR_HI && chr4k_mode) chr_hi4k <= commit_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prg_lo  <= '0;
      prg_hi  <= LAST_BANK;
      prg_32k <= '0;
    end else if (commit && tgt == TGT_PRG) begin
      unique case (pmode)
        PM_32K_A, PM_32K_B: prg_32k <= pval[PRG_W-1:1];
        PM_FIX_LO: begin
          prg_lo <= '0;
          prg_hi <= pval;
        end
        PM_FIX_HI: begin
          prg_lo <= pval;
          prg_hi <= LAST_BANK;
        end
      endcase
    end
  end

  // R3
  flush_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ctrl_q[3:2] == 2'b11) && $stable(chr_8k) && $stable(prg_lo));
  // R6
  chr8_keeps_4k_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && tgt == TGT_CHR_LO && !chr4k_mode) |=> $stable(chr_lo4k));
  // R7
  chr_hi_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && tgt == TGT_CHR_HI && !chr4k_mode) |=> $stable(chr_hi4k));
  // R9
  prg_fixlo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && tgt == TGT_PRG && pmode == PM_FIX_LO) |=> (prg_lo == '0));
  // R10
  prg_fixhi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && tgt == TGT_PRG && pmode == PM_FIX_HI) |=> (prg_hi == LAST_BANK));
  // R8
  prg_32k_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && tgt == TGT_PRG && !pmode[1]) |=> $stable(prg_lo) && $stable(prg_hi));
endmodule

// File: rtl/serial_bank_mapper.sv
module serial_bank_mapper
  import sbm_pkg::*;
#(
  parameter int PRG_BANKS = 16,
  localparam int PRG_W = $clog2(PRG_BANKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [15:0]      wr_addr,
  input  logic [7:0]       wr_data,
  output logic [4:0]       ctrl_value,
  output logic [1:0]       mirror_mode,
  output logic [4:0]       chr_lo4k_bank,
  output logic [4:0]       chr_hi4k_bank,
  output logic [4:0]       chr_8k_bank,
  output logic [1:0]       prg_mode,
  output logic [PRG_W-1:0] prg_bank_lo,
  output logic [PRG_W-1:0] prg_bank_hi,
  output logic [PRG_W-2:0] prg_bank32
);
  logic              take;
  logic              flush_wr;
  logic              commit;
  logic [LOAD_W-1:0] commit_val;
  logic [LOAD_W-1:0] ctrl_q;
  logic              unused_bits;

  assign wr_ready    = 1'b1;
  assign take        = wr_valid && wr_addr[15];
  assign flush_wr    = wr_data[7];
  assign unused_bits = ^{wr_addr[12:0], wr_data[6:1]};

  sbm_serial_loader u_loader (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .bit_in     (wr_data[0]),
    .flush      (flush_wr),
    .commit     (commit),
    .commit_val (commit_val)
  );

  sbm_bank_regs #(.PRG_BANKS(PRG_BANKS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit),
    .commit_val (commit_val),
    .target     (wr_addr[14:13]),
    .flush      (take && flush_wr),
    .ctrl_q     (ctrl_q),
    .chr_lo4k   (chr_lo4k_bank),
    .chr_hi4k   (chr_hi4k_bank),
    .chr_8k     (chr_8k_bank),
    .prg_lo     (prg_bank_lo),
    .prg_hi     (prg_bank_hi),
    .prg_32k    (prg_bank32)
  );

  assign ctrl_value  = ctrl_q;
  assign mirror_mode = ctrl_q[1:0];
  assign prg_mode    = ctrl_q[3:2];

  // R5
  mirror_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && wr_addr[14:13] == 2'd0) |=> (mirror_mode == $past(commit_val[1:0])));
endmodule

// File: tb/serial_bank_mapper_test.sv
module serial_bank_mapper_test;
  localparam int NB = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [4:0] ctrl_value, chr_lo4k_bank, chr_hi4k_bank, chr_8k_bank;
  logic [1:0] mirror_mode, prg_mode;
  logic [3:0] prg_bank_lo, prg_bank_hi;
  logic [2:0] prg_bank32;

  always #5 clk = ~clk;

  serial_bank_mapper #(.PRG_BANKS(NB)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .ctrl_value(ctrl_value),
    .mirror_mode(mirror_mode), .chr_lo4k_bank(chr_lo4k_bank),
    .chr_hi4k_bank(chr_hi4k_bank), .chr_8k_bank(chr_8k_bank),
    .prg_mode(prg_mode), .prg_bank_lo(prg_bank_lo),
    .prg_bank_hi(prg_bank_hi), .prg_bank32(prg_bank32)
  );

  typedef struct {
    logic [4:0] ctrl, c4lo, c4hi, c8;
    logic [3:0] lo, hi;
    logic [2:0] b32;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  event push_ev;
  int tests = 0;
  int fails = 0;

  logic [4:0] m_ctrl = 5'h0C, m_c4lo = '0, m_c4hi = '0, m_c8 = '0;
  logic [3:0] m_lo = '0, m_hi = 4'(NB - 1);
  logic [2:0] m_b32 = '0;

  task automatic chk(string tag, string what, int act, int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
    end
  endtask

  // Monitor: pops expected snapshots and compares the ports.
  initial begin
    forever begin
      @(push_ev);
      #1;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, "ctrl", ctrl_value, e.ctrl);
        chk(e.tag, "mirror", mirror_mode, e.ctrl[1:0]);
        chk(e.tag, "prg_mode", prg_mode, e.ctrl[3:2]);
        chk(e.tag, "chr_lo4k", chr_lo4k_bank, e.c4lo);
        chk(e.tag, "chr_hi4k", chr_hi4k_bank, e.c4hi);
        chk(e.tag, "chr_8k", chr_8k_bank, e.c8);
        chk(e.tag, "prg_lo", prg_bank_lo, e.lo);
        chk(e.tag, "prg_hi", prg_bank_hi, e.hi);
        chk(e.tag, "prg_32k", prg_bank32, e.b32);
      end
    end
  end

  task automatic push_expect(string tag);
    exp_t e;
    e.ctrl = m_ctrl; e.c4lo = m_c4lo; e.c4hi = m_c4hi; e.c8 = m_c8;
    e.lo = m_lo; e.hi = m_hi; e.b32 = m_b32; e.tag = tag;
    exp_q.push_back(e);
    -> push_ev;
    wait (exp_q.size() == 0);
    #2;
  endtask

  task automatic cpu_write(logic [15:0] a, logic [7:0] d, logic v = 1'b1);
    @(negedge clk);
    wr_valid = v;
    wr_addr  = a;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic model_commit(logic [15:0] a, logic [4:0] v);
    case (a[14:13])
      2'd0: m_ctrl = v;
      2'd1: if (m_ctrl[4]) m_c4lo = v; else m_c8 = v & 5'h1E;
      2'd2: if (m_ctrl[4]) m_c4hi = v;
      default: begin
        case (m_ctrl[3:2])
          2'd2: begin m_lo = '0; m_hi = v[3:0]; end
          2'd3: begin m_lo = v[3:0]; m_hi = 4'(NB - 1); end
          default: m_b32 = v[3:1];
        endcase
      end
    endcase
  endtask

  task automatic load(logic [15:0] a, logic [4:0] v, string tag);
    for (int i = 0; i < 5; i++) cpu_write(a, {7'b0101000, v[i]});
    model_commit(a, v);
    push_expect(tag);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    push_expect("R11 reset defaults");
    tests++;
    if (wr_ready !== 1'b1) begin
      fails++;
      $display("FAIL R12 wr_ready: actual %b expected 1", wr_ready);
    end

    // R4 R5: control via two addresses in its range, each mirroring code
    load(16'h8000, 5'h0E, "R5 R4 mirror vertical");
    load(16'h9FFF, 5'h0D, "R5 R4 mirror single upper");
    load(16'h8123, 5'h0F, "R5 mirror horizontal");
    load(16'h8000, 5'h0C, "R5 mirror single lower");

    // R6 R7: 8 KiB mode
    load(16'hA000, 5'h17, "R6 8k select masked");
    load(16'hC000, 5'h09, "R7 chr high ignored in 8k");

    // R6 R7: 4 KiB mode
    load(16'h8000, 5'h1C, "R2 ctrl 4k mode");
    load(16'hBFFF, 5'h13, "R6 4k low select");
    load(16'hDFFF, 5'h0B, "R7 4k high select");

    // R10 R9 R8: program modes
    load(16'hE000, 5'h05, "R10 fixed upper");
    load(16'h8000, 5'h18, "R9 ctrl mode 2");
    load(16'hFFFF, 5'h07, "R9 fixed lower");
    load(16'h8000, 5'h10, "R8 ctrl mode 0");
    load(16'hE000, 5'h0B, "R8 32k mode 0");
    load(16'h8000, 5'h14, "R8 ctrl mode 1");
    load(16'hE000, 5'h16, "R8 32k mode 1");

    // R2: partial load shows nothing
    cpu_write(16'hE000, 8'h01);
    cpu_write(16'hE000, 8'h00);
    cpu_write(16'hE000, 8'h01);
    push_expect("R2 partial no change");

    // R3: clear mid-load, ctrl bits 3:2 forced
    cpu_write(16'hA000, 8'h80);
    m_ctrl = m_ctrl | 5'h0C;
    push_expect("R3 clear forces mode");
    load(16'hA000, 5'h1F, "R3 load realigned after clear");

    // R1: out-of-window and idle cycles are ignored
    for (int i = 0; i < 4; i++) cpu_write(16'h7FFF, 8'h81);
    for (int i = 0; i < 3; i++) cpu_write(16'hE000, 8'h81, 1'b0);
    push_expect("R1 ignored writes no change");
    load(16'h8000, 5'h01, "R1 load still aligned");
    load(16'hC000, 5'h1E, "R1 R7 no stray shift");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule